// File: doc/BRIEF.md
# Framebuffer controller register file

This block is the configuration register bank of a raster display framebuffer controller. A bus master reads and writes fourteen 32-bit registers through a word-addressed port. The registers hold the controller's enable, the horizontal and vertical timing values, the framebuffer base address, the burst length and two free words: one for a display data channel and one for the pixel clock source. The block drives these values out as configuration signals for the timing and fetch logic that sits next to it.

The block also applies the write rules for the base address. A write is accepted only if it is 32-byte aligned, and the stored value is clipped by a mask parameter. A read-only register mirrors the base. The block issues two one-cycle events: a resize request when the timing geometry or enable changes on a running controller, and an invalidate request when a new base is accepted. It also computes the scanout start address and the line pitch for 16-bit pixels. An access to an unknown register, a write to the mirror, or a misaligned base write raises a one-cycle error pulse.

Top module: `fbctl_regs`

## Requirements
- R1: After reset the control word reads 1, the horizontal resolution reads 640, the vertical resolution reads 480, and every other register reads 0.
- R2: Registers sit at consecutive word indices given by `bus_addr[AW-1:2]`: 0 control, 1 h_res, 2 hsync begin, 3 hsync end, 4 h_total, 5 v_res, 6 vsync begin, 7 vsync end, 8 v_total, 9 base, 10 base mirror, 11 burst, 12 ddc word, 13 pixel clock word. Byte address bits [1:0] are ignored. A write stores all 32 bits. A read request's data appears on `bus_rdata` one clock later.
- R3: `disp_enable` is 1 exactly while bit 0 of the control word is 0.
- R4: A base write with any of bits [4:0] set leaves the base unchanged, raises no invalidate, and pulses `bus_err`.
- R5: An aligned base write stores the data ANDed with `BASE_MASK` and pulses `invalidate_req`.
- R6: Reading index 10 returns the current base. A write to index 10 changes nothing and pulses `bus_err`.
- R7: A write to index 0, 1 or 5 pulses `resize_req` only if bit 0 of the control word is 0 after that write. No other write pulses it.
- R8: Indices 14 and above read as 0. Writes to them change nothing, and any access to them pulses `bus_err`.
- R9: `scan_base` equals the base plus `FB_OFFSET`, `line_bytes` equals twice h_res, and `v_res` gives the line count.
- R10: `bus_err`, `resize_req` and `invalidate_req` are high for exactly the one cycle after the access that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle error pulse |
| disp_enable | output | 1 | Controller running |
| h_res | output | 32 | Horizontal resolution |
| h_sync_beg | output | 32 | Horizontal sync begin |
| h_sync_fin | output | 32 | Horizontal sync end |
| h_total | output | 32 | Horizontal total scan |
| v_res | output | 32 | Vertical resolution (line count) |
| v_sync_beg | output | 32 | Vertical sync begin |
| v_sync_fin | output | 32 | Vertical sync end |
| v_total | output | 32 | Vertical total scan |
| burst_len | output | 32 | Burst count |
| ddc_word | output | 32 | Display data channel word |
| pixclk_word | output | 32 | Pixel clock source word |
| scan_base | output | 32 | Scanout start address |
| line_bytes | output | 32 | Bytes per line |
| resize_req | output | 1 | Resize event pulse |
| invalidate_req | output | 1 | Invalidate event pulse |

## Verification
Every one of the sixteen word indices is written with four data patterns and then read back in full, with the byte offset bits varied. The patterns differ in two ways: aligned or misaligned base, and control bit 0 set or clear. As a result, the masking, the discard of misaligned writes and the read-only mirror are each seen against a register that is known to change. Because the control patterns switch the controller off and on again between passes, the same resolution writes are seen both with and without a resize event. Reading back the unmapped indices after writing them shows that those writes did nothing.

// File: rtl/fbctl_regs.sv
module fbctl_regs #(
  parameter int          AW        = 6,
  parameter logic [31:0] BASE_MASK = 32'hFFFF_FFFF,
  parameter logic [31:0] FB_OFFSET = 32'h0,
  parameter logic [31:0] HRES_RST  = 32'd640,
  parameter logic [31:0] VRES_RST  = 32'd480
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_err,
  output logic          disp_enable,
  output logic [31:0]   h_res,
  output logic [31:0]   h_sync_beg,
  output logic [31:0]   h_sync_fin,
  output logic [31:0]   h_total,
  output logic [31:0]   v_res,
  output logic [31:0]   v_sync_beg,
  output logic [31:0]   v_sync_fin,
  output logic [31:0]   v_total,
  output logic [31:0]   burst_len,
  output logic [31:0]   ddc_word,
  output logic [31:0]   pixclk_word,
  output logic [31:0]   scan_base,
  output logic [31:0]   line_bytes,
  output logic          resize_req,
  output logic          invalidate_req
);
  localparam int IW   = AW - 2;
  localparam int NREG = 14;
  localparam logic [IW-1:0] IX_CTRL = IW'(0);
  localparam logic [IW-1:0] IX_HRES = IW'(1);
  localparam logic [IW-1:0] IX_VRES = IW'(5);
  localparam logic [IW-1:0] IX_BASE = IW'(9);
  localparam logic [IW-1:0] IX_MIRR = IW'(10);
  localparam logic [IW-1:0] IX_LAST = IW'(NREG - 1);

  logic [31:0]   regs [NREG];
  logic [IW-1:0] idx;
  logic          mapped, wr, rd, aligned, ctrl_after;
  logic [31:0]   rd_mux;
  wire           unused_ok = &{1'b0, bus_addr[1:0]};

  assign idx     = bus_addr[AW-1:2];
  assign mapped  = idx <= IX_LAST;
  assign wr      = bus_valid && bus_we;
  assign rd      = bus_valid && !bus_we;
  assign aligned = bus_wdata[4:0] == 5'd0;
  assign ctrl_after = (idx == IX_CTRL) ? bus_wdata[0] : regs[0][0];

  function automatic logic [31:0] rst_val(int i);
    case (i)
      0:       return 32'd1;
      1:       return HRES_RST;
      5:       return VRES_RST;
      default: return 32'd0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n)
        regs[i] <= rst_val(i);
      else if (wr && idx == IW'(i) && idx != IX_MIRR) begin
        if (idx != IX_BASE)
          regs[i] <= bus_wdata;
        else if (aligned)
          regs[i] <= bus_wdata & BASE_MASK;
      end
    end
  end

  always_comb begin
    rd_mux = 32'd0;
    if (idx == IX_MIRR)
      rd_mux = regs[9];
    else if (mapped)
      rd_mux = regs[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata      <= 32'd0;
      bus_err        <= 1'b0;
      resize_req     <= 1'b0;
      invalidate_req <= 1'b0;
    end else begin
      if (rd)
        bus_rdata <= rd_mux;
      bus_err        <= bus_valid && (!mapped ||
                        (bus_we && (idx == IX_MIRR || (idx == IX_BASE && !aligned))));
      resize_req     <= wr && (idx == IX_CTRL || idx == IX_HRES || idx == IX_VRES) && !ctrl_after;
      invalidate_req <= wr && idx == IX_BASE && aligned;
    end
  end

  assign disp_enable = !regs[0][0];
  assign h_res       = regs[1];
  assign h_sync_beg  = regs[2];
  assign h_sync_fin  = regs[3];
  assign h_total     = regs[4];
  assign v_res       = regs[5];
  assign v_sync_beg  = regs[6];
  assign v_sync_fin  = regs[7];
  assign v_total     = regs[8];
  assign burst_len   = regs[11];
  assign ddc_word    = regs[12];
  assign pixclk_word = regs[13];
  assign scan_base   = regs[9] + FB_OFFSET;
  assign line_bytes  = {regs[1][30:0], 1'b0};

  // R4
  misaligned_base_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IX_BASE && !aligned) |=> ($stable(scan_base) && bus_err && !invalidate_req));
  // R5
  inval_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate_req |-> $past(wr && idx == IX_BASE && bus_wdata[4:0] == 5'd0));
  // R6
  mirror_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IX_MIRR) |=> (bus_err && $stable(scan_base)));
  // R7
  resize_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resize_req |-> ($past(wr && (idx == IX_CTRL || idx == IX_HRES || idx == IX_VRES)) && disp_enable));
  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !mapped) |=> (bus_rdata == 32'd0 && bus_err));
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resize_req || invalidate_req || bus_err) |-> $past(bus_valid));
endmodule

// File: tb/fbctl_regs_bench.sv
module fbctl_regs_bench;
  localparam logic [31:0] MASK = 32'h0FFF_FFC0;
  localparam logic [31:0] OFFS = 32'h0000_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, h_res, h_sync_beg, h_sync_fin, h_total, v_res, v_sync_beg,
               v_sync_fin, v_total, burst_len, ddc_word, pixclk_word, scan_base, line_bytes;
  logic bus_err, disp_enable, resize_req, invalidate_req;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] m [16];

  always #10 clk = ~clk;

  fbctl_regs #(.AW(6), .BASE_MASK(MASK), .FB_OFFSET(OFFS)) u_fbctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .disp_enable(disp_enable),
    .h_res(h_res), .h_sync_beg(h_sync_beg), .h_sync_fin(h_sync_fin), .h_total(h_total),
    .v_res(v_res), .v_sync_beg(v_sync_beg), .v_sync_fin(v_sync_fin), .v_total(v_total),
    .burst_len(burst_len), .ddc_word(ddc_word), .pixclk_word(pixclk_word),
    .scan_base(scan_base), .line_bytes(line_bytes), .resize_req(resize_req),
    .invalidate_req(invalidate_req));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit we, input int ix, input logic [1:0] lo, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = {ix[3:0], lo}; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [31:0] expect_rd(int ix);
    if (ix == 10) return m[9];
    if (ix >= 14) return 32'd0;
    return m[ix];
  endfunction

  task automatic read_all(input string req, input logic [1:0] lo);
    for (int i = 0; i < 16; i++) begin
      op(1'b0, i, lo, 32'h0);
      chk(bus_rdata == expect_rd(i), req, bus_rdata, expect_rd(i));
      chk(bus_err == (i >= 14), "R8 read err", 32'(bus_err), 32'(i >= 14));
      chk(!resize_req && !invalidate_req, "R10 no pulse on read", 32'({resize_req, invalidate_req}), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hA5C3_7E40; pats[1] = 32'h1234_5671;
    pats[2] = 32'hF0F0_F0E0; pats[3] = 32'h0000_0008;
    for (int i = 0; i < 16; i++) m[i] = 32'd0;
    m[0] = 32'd1; m[1] = 32'd640; m[5] = 32'd480;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(disp_enable == 1'b0, "R1/R3 enable after reset", 32'(disp_enable), 0);
    chk(line_bytes == 32'd1280, "R1/R9 line bytes", line_bytes, 32'd1280);
    chk(scan_base == OFFS, "R1/R9 scan base", scan_base, OFFS);
    read_all("R1 reset value", 2'd0);
    for (int p = 0; p < 4; p++) begin
      for (int ix = 0; ix < 16; ix++) begin
        logic [31:0] d;
        bit mis, e_err, e_rsz, e_inv;
        logic [31:0] nctrl;
        d = pats[p] ^ 32'(ix << 8);
        if (ix == 9) d = pats[p];
        mis = d[4:0] != 5'd0;
        nctrl = (ix == 0) ? d : m[0];
        e_err = ix >= 14 || ix == 10 || (ix == 9 && mis);
        e_rsz = (ix == 0 || ix == 1 || ix == 5) && !nctrl[0];
        e_inv = ix == 9 && !mis;
        if (ix < 14 && ix != 10 && !(ix == 9 && mis)) m[ix] = (ix == 9) ? (d & MASK) : d;
        op(1'b1, ix, 2'(p), d);
        chk(bus_err == e_err, "R4/R6/R8 write err", 32'(bus_err), 32'(e_err));
        chk(resize_req == e_rsz, "R7 resize", 32'(resize_req), 32'(e_rsz));
        chk(invalidate_req == e_inv, "R5 invalidate", 32'(invalidate_req), 32'(e_inv));
        chk(disp_enable == !m[0][0], "R3 enable", 32'(disp_enable), 32'(!m[0][0]));
        chk(scan_base == m[9] + OFFS, "R9 scan base", scan_base, m[9] + OFFS);
        chk(line_bytes == m[1] * 2, "R9 line bytes", line_bytes, m[1] * 2);
        chk(v_res == m[5] && h_total == m[4] && pixclk_word == m[13], "R2 outputs",
            v_res ^ h_total ^ pixclk_word, m[5] ^ m[4] ^ m[13]);
        @(negedge clk);
        chk(!bus_err && !resize_req && !invalidate_req, "R10 single cycle",
            32'({bus_err, resize_req, invalidate_req}), 0);
        if (ix == 9 || ix == 10 || ix >= 14) read_all("R2/R4/R6/R8 readback", 2'(3 - p));
      end
      read_all("R2 readback", 2'(p));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule